// File: doc/BRIEF.md
# Macro Instruction Sequencer

This block steps through a short macro program held in an instruction memory. A run begins on a start pulse. The pulse supplies an entry word offset and the first parameter word. The block then clears its eight-entry general register file, loads register 1 with that parameter and resets its byte program counter to zero. It then fetches one 32-bit instruction at a time from a synchronous memory port. Each legal non-branch instruction is issued to the neighbouring datapath together with its two source register values. The datapath writes its results back through a write port.

The sequencer resolves branches and exits by itself. A branch tests one register for zero or nonzero. Its target is relative to the branch's own address. A taken branch runs its delay slot unless the annul bit is set. An exit lets one more instruction run and then ends the run. An exit placed in a branch delay slot ends the run only after the branch target has run. A branch in any delay slot, or the reserved opcode, ends the run with an error.

Top module: `macro_seq_top`

## Requirements
- R1: A start pulse while idle clears every register, loads register 1 with `param0_i`, sets the program counter to 0 and the parameter index to 1, and raises `busy_o` on the next cycle. A start pulse while busy is ignored.
- R2: Register 0 always reads as zero, and writes to it are discarded.
- R3: Each fetch reads word address `entry + pc/4`. The program counter then advances by 4. Each fetch takes one memory cycle, so an instruction issues at most every second cycle.
- R4: Opcode 7 (bits 2:0) is a branch. It tests `src_a` (bits 11:9) for zero when bit 4 is 0, or for nonzero when bit 4 is 1. Its target is the branch address plus 4 times the signed word offset in bits 31:15.
- R5: For a taken branch with the annul bit (bit 5) clear, the next sequential instruction runs first, and then control moves to the target.
- R6: For a taken branch with the annul bit set, control moves straight to the target and no delay slot runs.
- R7: An instruction with the exit bit (bit 3) set is followed by exactly one more instruction, after which the run halts.
- R8: An exit bit on the instruction in a branch delay slot lets the branch target instruction run, and then the run halts.
- R9: A branch that sits in a branch delay slot or an exit delay slot is not issued. The run halts with `error_o` set.
- R10: Opcode 6 is reserved. It is not issued, and the run halts with `error_o` set.
- R11: `done_o` is a one-cycle pulse in the cycle in which `busy_o` falls. `error_o` holds its value until the next start.
- R12: Every executed non-branch-resolution instruction pulses `issue_o` with its word on `instr_o`, its byte address on `issue_pc_o`, and the current values of its source registers on `src_a_o`/`src_b_o` (`src_b` is bits 14:12). A result written back in the issue cycle is visible to the next instruction.
- R13: Each `param_take_i` pulse during a run increments `param_idx_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a run (when idle) |
| entry_i | input | IMEM_AW | Entry word offset of the macro |
| param0_i | input | 32 | First parameter word, loaded into register 1 |
| imem_en_o | output | 1 | Instruction memory read enable |
| imem_addr_o | output | IMEM_AW | Instruction memory word address |
| imem_rdata_i | input | 32 | Instruction word, valid the cycle after the read |
| issue_o | output | 1 | An instruction is issued to the datapath |
| instr_o | output | 32 | Issued instruction word |
| issue_pc_o | output | IMEM_AW+2 | Byte address of the issued instruction |
| src_a_o | output | 32 | Value of source register A |
| src_b_o | output | 32 | Value of source register B |
| wb_en_i | input | 1 | Register write enable from the datapath |
| wb_idx_i | input | 3 | Register write index |
| wb_data_i | input | 32 | Register write data |
| param_take_i | input | 1 | Datapath consumed one parameter word |
| param_idx_o | output | PIDX_W | Index of the next parameter word |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle pulse when a run ends |
| error_o | output | 1 | Last run ended on an illegal instruction |

## Verification
The bench builds the block with the defaults: an 8-bit instruction word address and an 8-bit parameter index. With these, every macro is placed at its own nonzero entry offset within a 256-word memory. Negative branch offsets then wrap inside the 10-bit program counter, which exercises both backward and forward targets. A bench-side datapath stub writes back a value derived from each issue address, which makes register hazards and register-0 discards visible at the source outputs.

// File: rtl/macro_seq_pkg.sv
package macro_seq_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned NUM_REGS = 8;
  localparam int unsigned REG_AW   = 3;
  localparam int unsigned OFF_W    = 17;

  localparam logic [2:0] OP_RESERVED = 3'd6;
  localparam logic [2:0] OP_BRANCH   = 3'd7;

  typedef struct packed {
    logic [OFF_W-1:0]  off;
    logic [REG_AW-1:0] src_b;
    logic [REG_AW-1:0] src_a;
    logic [REG_AW-1:0] dst;
    logic              annul;
    logic              cond_nz;
    logic              exit_f;
    logic [2:0]        op;
  } instr_t;

  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_EXEC} seq_state_e;
  typedef enum logic [1:0] {SL_NONE, SL_BRANCH, SL_EXIT} slot_e;
endpackage

// File: rtl/macro_regfile.sv
module macro_regfile #(
  parameter int unsigned NREGS = 8,
  parameter int unsigned DW    = 32,
  localparam int unsigned AW   = $clog2(NREGS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic [DW-1:0] init_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_a_i,
  input  logic [AW-1:0] raddr_b_i,
  output logic [DW-1:0] rdata_a_o,
  output logic [DW-1:0] rdata_b_o
);
  logic [DW-1:0] regs [NREGS];

  for (genvar i = 0; i < NREGS; i++) begin : g_reg
    if (i == 0) begin : g_zero
      assign regs[i] = '0;
    end else begin : g_flop
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                              regs[i] <= '0;
        else if (clear_i)                         regs[i] <= (i == 1) ? init_i : '0;
        else if (we_i && waddr_i == AW'(i))       regs[i] <= wdata_i;
      end
    end
  end

  assign rdata_a_o = regs[raddr_a_i];
  assign rdata_b_o = regs[raddr_b_i];
endmodule

// File: rtl/macro_branch_eval.sv
module macro_branch_eval #(
  parameter int unsigned PC_W  = 10,
  parameter int unsigned OFF_W = 17,
  parameter int unsigned DW    = 32
) (
  input  logic             cond_nz_i,
  input  logic [DW-1:0]    value_i,
  input  logic [PC_W-1:0]  pc_i,
  input  logic [OFF_W-1:0] off_i,
  output logic             taken_o,
  output logic [PC_W-1:0]  target_o
);
  logic              is_zero;
  logic [OFF_W+1:0]  off_bytes;
  logic [31:0]       off_ext;

  assign is_zero   = (value_i == '0);
  assign taken_o   = cond_nz_i ? !is_zero : is_zero;
  assign off_bytes = {off_i, 2'b00};
  assign off_ext   = 32'(signed'(off_bytes));
  assign target_o  = pc_i + off_ext[PC_W-1:0];
endmodule

// File: rtl/macro_seq_top.sv
module macro_seq_top
  import macro_seq_pkg::*;
#(
  parameter int unsigned IMEM_AW = 8,
  parameter int unsigned PIDX_W  = 8,
  localparam int unsigned PC_W   = IMEM_AW + 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [IMEM_AW-1:0] entry_i,
  input  logic [WORD_W-1:0]  param0_i,
  output logic               imem_en_o,
  output logic [IMEM_AW-1:0] imem_addr_o,
  input  logic [WORD_W-1:0]  imem_rdata_i,
  output logic               issue_o,
  output logic [WORD_W-1:0]  instr_o,
  output logic [PC_W-1:0]    issue_pc_o,
  output logic [WORD_W-1:0]  src_a_o,
  output logic [WORD_W-1:0]  src_b_o,
  input  logic               wb_en_i,
  input  logic [REG_AW-1:0]  wb_idx_i,
  input  logic [WORD_W-1:0]  wb_data_i,
  input  logic               param_take_i,
  output logic [PIDX_W-1:0]  param_idx_o,
  output logic               busy_o,
  output logic               done_o,
  output logic               error_o
);
  seq_state_e         state_q;
  slot_e              slot_q, slot_n;
  logic [PC_W-1:0]    pc_q, pc_n, pend_q, br_target;
  logic [IMEM_AW-1:0] entry_q;
  logic               last_q, done_q, err_q;
  logic [PIDX_W-1:0]  pidx_q;
  instr_t             ins;
  logic               in_exec, is_br, br_taken, bad, halt, launch;

  assign ins     = instr_t'(imem_rdata_i);
  assign in_exec = (state_q == ST_EXEC);
  assign busy_o  = (state_q != ST_IDLE);
  assign launch  = start_i && (state_q == ST_IDLE);

  macro_regfile #(.NREGS(NUM_REGS), .DW(WORD_W)) u_rf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (launch),
    .init_i    (param0_i),
    .we_i      (wb_en_i && busy_o),
    .waddr_i   (wb_idx_i),
    .wdata_i   (wb_data_i),
    .raddr_a_i (ins.src_a),
    .raddr_b_i (ins.src_b),
    .rdata_a_o (src_a_o),
    .rdata_b_o (src_b_o)
  );

  macro_branch_eval #(.PC_W(PC_W), .OFF_W(OFF_W), .DW(WORD_W)) u_br (
    .cond_nz_i (ins.cond_nz),
    .value_i   (src_a_o),
    .pc_i      (pc_q),
    .off_i     (ins.off),
    .taken_o   (br_taken),
    .target_o  (br_target)
  );

  assign is_br = (ins.op == OP_BRANCH);
  // illegal: reserved opcode, or a branch inside any delay slot
  assign bad   = (ins.op == OP_RESERVED) || (is_br && slot_q != SL_NONE);
  assign halt  = bad || (slot_q == SL_EXIT) || last_q;

  always_comb begin
    pc_n   = pc_q + PC_W'(4);
    slot_n = SL_NONE;
    if (slot_q == SL_BRANCH) begin
      pc_n = pend_q;
    end else if (slot_q == SL_NONE) begin
      if (is_br && br_taken) begin
        if (ins.annul) pc_n = br_target;
        else           slot_n = SL_BRANCH;
      end else if (ins.exit_f) begin
        slot_n = SL_EXIT;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      slot_q  <= SL_NONE;
      pc_q    <= '0;
      pend_q  <= '0;
      entry_q <= '0;
      last_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_FETCH;
          slot_q  <= SL_NONE;
          pc_q    <= '0;
          entry_q <= entry_i;
          last_q  <= 1'b0;
          err_q   <= 1'b0;
        end
        ST_FETCH: state_q <= ST_EXEC;
        ST_EXEC: if (halt) begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
          err_q   <= bad;
        end else begin
          state_q <= ST_FETCH;
          pc_q    <= pc_n;
          slot_q  <= slot_n;
          last_q  <= (slot_q == SL_BRANCH) && ins.exit_f;
          if (slot_n == SL_BRANCH) pend_q <= br_target;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    pidx_q <= '0;
    else if (launch)                pidx_q <= PIDX_W'(1);
    else if (busy_o && param_take_i) pidx_q <= pidx_q + PIDX_W'(1);
  end

  assign imem_en_o   = (state_q == ST_FETCH);
  assign imem_addr_o = entry_q + pc_q[PC_W-1:2];
  assign issue_o     = in_exec && !bad && !is_br;
  assign instr_o     = imem_rdata_i;
  assign issue_pc_o  = pc_q;
  assign param_idx_o = pidx_q;
  assign done_o      = done_q;
  assign error_o     = err_q;
endmodule

// File: rtl/macro_seq_chk.sv
module macro_seq_chk
  import macro_seq_pkg::*;
#(
  parameter int unsigned PIDX_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              imem_en_o,
  input logic              issue_o,
  input logic [WORD_W-1:0] instr_o,
  input logic [WORD_W-1:0] src_a_o,
  input logic [PIDX_W-1:0] param_idx_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              error_o
);
  AST_ISSUE_IN_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_o |-> busy_o); // R12
  AST_ISSUE_NOT_BRANCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_o |-> instr_o[2:0] != OP_BRANCH); // R12
  AST_ISSUE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_o |-> instr_o[2:0] != OP_RESERVED); // R10
  AST_R0_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_o && instr_o[11:9] == 3'd0) |-> src_a_o == '0); // R2
  AST_FETCH_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    imem_en_o |=> !imem_en_o); // R3
  AST_ISSUE_AFTER_FETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_o |-> $past(imem_en_o)); // R3
  AST_START_INIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (busy_o && param_idx_o == PIDX_W'(1))); // R1
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R11
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R11
  AST_ERROR_AT_HALT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(error_o) |-> done_o); // R9
endmodule

bind macro_seq_top macro_seq_chk #(.PIDX_W(PIDX_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .imem_en_o   (imem_en_o),
  .issue_o     (issue_o),
  .instr_o     (instr_o),
  .src_a_o     (src_a_o),
  .param_idx_o (param_idx_o),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .error_o     (error_o)
);

// File: tb/tb_macro_seq_top.sv
module tb_macro_seq_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [7:0]  entry_i = '0;
  logic [31:0] param0_i = '0;
  logic        imem_en;
  logic [7:0]  imem_addr;
  logic [31:0] imem_rdata = '0;
  logic        issue;
  logic [31:0] instr, src_a, src_b;
  logic [9:0]  issue_pc;
  logic        wb_en = 1'b0;
  logic [2:0]  wb_idx = '0;
  logic [31:0] wb_data = '0;
  logic        param_take = 1'b0;
  logic [7:0]  param_idx;
  logic        busy, done, error;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  logic [31:0] mem [256];
  int tr_n, fa_n;
  int tr_pc [16];
  int tr_cyc [16];
  logic [31:0] tr_sa [16];
  logic [31:0] tr_sb [16];
  int fa [16];

  always #5 clk = ~clk;
  always @(posedge clk) cyc++;

  macro_seq_top dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .entry_i(entry_i), .param0_i(param0_i),
    .imem_en_o(imem_en), .imem_addr_o(imem_addr), .imem_rdata_i(imem_rdata),
    .issue_o(issue), .instr_o(instr), .issue_pc_o(issue_pc), .src_a_o(src_a), .src_b_o(src_b),
    .wb_en_i(wb_en), .wb_idx_i(wb_idx), .wb_data_i(wb_data), .param_take_i(param_take),
    .param_idx_o(param_idx), .busy_o(busy), .done_o(done), .error_o(error)
  );

  always @(posedge clk) if (imem_en) imem_rdata <= mem[imem_addr];

  // datapath stub and trace monitor
  always @(negedge clk) begin
    wb_en      = issue;
    wb_idx     = instr[8:6];
    wb_data    = 32'hA500_0000 | 32'(issue_pc);
    param_take = issue && instr[2:0] == 3'd1;
    if (issue && tr_n < 16) begin
      tr_pc[tr_n] = int'(issue_pc); tr_cyc[tr_n] = cyc;
      tr_sa[tr_n] = src_a; tr_sb[tr_n] = src_b; tr_n++;
    end
    if (imem_en && fa_n < 16) begin fa[fa_n] = int'(imem_addr); fa_n++; end
  end

  function automatic logic [31:0] enc(input logic [2:0] op, input bit ex, input bit cnz, input bit ann,
                                      input logic [2:0] d, input logic [2:0] sa, input logic [2:0] sb,
                                      input int off);
    logic [16:0] o;
    o = 17'(off);
    return {o, sb, sa, d, ann, cnz, ex, op};
  endfunction

  function automatic logic [31:0] nop(input logic [2:0] op, input bit ex, input logic [2:0] d,
                                      input logic [2:0] sa, input logic [2:0] sb);
    return enc(op, ex, 1'b0, 1'b0, d, sa, sb, 0);
  endfunction

  function automatic logic [31:0] br(input bit cnz, input bit ann, input logic [2:0] sa, input int off);
    return enc(3'd7, 1'b0, cnz, ann, 3'd0, sa, 3'd0, off);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem[i] = nop(3'd0, 1'b1, 3'd0, 3'd0, 3'd0);
  endtask

  task automatic run(input logic [7:0] entry, input logic [31:0] p0, input bit restart_mid);
    int cnt;
    tr_n = 0; fa_n = 0; cnt = 0;
    @(negedge clk); start_i = 1'b1; entry_i = entry; param0_i = p0;
    @(negedge clk); start_i = 1'b0;
    chk("R11 error cleared by start", 32'(error), 32'd0);
    if (restart_mid) begin start_i = 1'b1; entry_i = entry + 8'd8; param0_i = 32'hDEAD; end
    @(negedge clk); start_i = 1'b0;
    while (!done && cnt < 300) begin @(negedge clk); cnt++; end
    if (cnt >= 300) begin n_bad++; $display("FAIL R7 run timeout actual=busy expected=done"); end
    chk("R11 busy low with done", 32'(busy), 32'd0);
    @(negedge clk);
    chk("R11 done one cycle", 32'(done), 32'd0);
  endtask

  task automatic chk_trace(input string req, input int n, input int e0, input int e1,
                           input int e2, input int e3);
    int e [4];
    e = '{e0, e1, e2, e3};
    chk({req, " trace length"}, 32'(tr_n), 32'(n));
    for (int i = 0; i < n && i < 4; i++) chk({req, " trace pc"}, 32'(tr_pc[i]), 32'(e[i]));
  endtask

  task automatic t_reset();
    chk("R11 reset busy", 32'(busy), 32'd0);
    chk("R11 reset done", 32'(done), 32'd0);
    chk("R11 reset error", 32'(error), 32'd0);
    chk("R3 reset no fetch", 32'(imem_en), 32'd0);
  endtask

  task automatic t_straight();
    clear_mem();
    mem[10] = nop(3'd0, 1'b0, 3'd2, 3'd1, 3'd0);
    mem[11] = nop(3'd1, 1'b1, 3'd3, 3'd2, 3'd0);
    mem[12] = nop(3'd0, 1'b0, 3'd4, 3'd3, 3'd2);
    mem[13] = nop(3'd0, 1'b0, 3'd4, 3'd0, 3'd0);
    run(8'd10, 32'h1234_5678, 1'b0);
    chk_trace("R7", 3, 0, 4, 8, 0);
    chk("R1 r1 holds param", tr_sa[0], 32'h1234_5678);
    chk("R12 writeback visible", tr_sa[1], 32'hA500_0000);
    chk("R12 src a", tr_sa[2], 32'hA500_0004);
    chk("R12 src b", tr_sb[2], 32'hA500_0000);
    chk("R3 fetch addr 0", 32'(fa[0]), 32'd10);
    chk("R3 fetch addr 2", 32'(fa[2]), 32'd12);
    chk("R3 issue spacing", 32'(tr_cyc[1] - tr_cyc[0]), 32'd2);
    chk("R13 param index", 32'(param_idx), 32'd2);
    chk("R7 no error", 32'(error), 32'd0);
  endtask

  task automatic t_clear();
    clear_mem();
    mem[30] = nop(3'd0, 1'b1, 3'd0, 3'd2, 3'd0);
    mem[31] = nop(3'd0, 1'b0, 3'd5, 3'd0, 3'd0);
    run(8'd30, 32'd7, 1'b0);
    chk_trace("R1", 2, 0, 4, 0, 0);
    chk("R1 registers cleared", tr_sa[0], 32'd0);
    chk("R2 r0 write discarded", tr_sa[1], 32'd0);
    chk("R1 param index starts at 1", 32'(param_idx), 32'd1);
  endtask

  task automatic t_branch_slot();
    clear_mem();
    mem[50] = br(1'b0, 1'b0, 3'd0, 3);
    mem[51] = nop(3'd0, 1'b0, 3'd2, 3'd0, 3'd0);
    mem[52] = nop(3'd0, 1'b0, 3'd2, 3'd0, 3'd0);
    mem[53] = nop(3'd0, 1'b1, 3'd2, 3'd0, 3'd0);
    mem[54] = nop(3'd0, 1'b0, 3'd2, 3'd0, 3'd0);
    run(8'd50, 32'd1, 1'b1);
    chk_trace("R5", 3, 4, 12, 16, 0);
    chk("R1 restart while busy ignored", 32'(fa[0]), 32'd50);
    chk("R5 no error", 32'(error), 32'd0);
  endtask

  task automatic t_annul();
    clear_mem();
    mem[70] = br(1'b0, 1'b1, 3'd0, 3);
    mem[71] = nop(3'd0, 1'b0, 3'd2, 3'd0, 3'd0);
    mem[73] = nop(3'd0, 1'b1, 3'd2, 3'd0, 3'd0);
    mem[74] = nop(3'd0, 1'b0, 3'd2, 3'd0, 3'd0);
    run(8'd70, 32'd1, 1'b0);
    chk_trace("R6", 2, 12, 16, 0, 0);
    chk("R6 fetch count", 32'(fa_n), 32'd3);
  endtask

  task automatic t_not_taken();
    clear_mem();
    mem[90] = br(1'b1, 1'b0, 3'd1, 3);
    mem[91] = nop(3'd0, 1'b1, 3'd2, 3'd0, 3'd0);
    mem[92] = nop(3'd0, 1'b0, 3'd2, 3'd0, 3'd0);
    run(8'd90, 32'd0, 1'b0);
    chk_trace("R4 not taken", 2, 4, 8, 0, 0);
  endtask

  task automatic t_backward();
    clear_mem();
    mem[110] = br(1'b1, 1'b1, 3'd1, 4);
    mem[114] = br(1'b0, 1'b1, 3'd0, -3);
    mem[111] = nop(3'd0, 1'b1, 3'd2, 3'd0, 3'd0);
    mem[112] = nop(3'd0, 1'b0, 3'd2, 3'd0, 3'd0);
    run(8'd110, 32'd5, 1'b0);
    chk_trace("R4 relative", 2, 4, 8, 0, 0);
    chk("R4 fetch after forward", 32'(fa[1]), 32'd114);
    chk("R4 fetch after backward", 32'(fa[2]), 32'd111);
  endtask

  task automatic t_exit_in_slot();
    clear_mem();
    mem[130] = br(1'b0, 1'b0, 3'd0, 5);
    mem[131] = nop(3'd0, 1'b1, 3'd2, 3'd0, 3'd0);
    mem[132] = nop(3'd0, 1'b0, 3'd2, 3'd0, 3'd0);
    mem[135] = nop(3'd0, 1'b0, 3'd2, 3'd0, 3'd0);
    mem[136] = nop(3'd0, 1'b0, 3'd2, 3'd0, 3'd0);
    run(8'd130, 32'd1, 1'b0);
    chk_trace("R8", 2, 4, 20, 0, 0);
    chk("R8 no error", 32'(error), 32'd0);
  endtask

  task automatic t_branch_in_slot();
    clear_mem();
    mem[150] = br(1'b0, 1'b0, 3'd0, 5);
    mem[151] = br(1'b0, 1'b0, 3'd0, 2);
    run(8'd150, 32'd1, 1'b0);
    chk_trace("R9 branch slot", 0, 0, 0, 0, 0);
    chk("R9 error on branch in branch slot", 32'(error), 32'd1);
    chk("R9 halted at slot", 32'(fa_n), 32'd2);
  endtask

  task automatic t_branch_in_exit_slot();
    clear_mem();
    mem[170] = nop(3'd0, 1'b1, 3'd2, 3'd0, 3'd0);
    mem[171] = br(1'b0, 1'b1, 3'd0, 4);
    run(8'd170, 32'd1, 1'b0);
    chk_trace("R9 exit slot", 1, 0, 0, 0, 0);
    chk("R9 error on branch in exit slot", 32'(error), 32'd1);
  endtask

  task automatic t_reserved();
    clear_mem();
    mem[190] = nop(3'd0, 1'b0, 3'd2, 3'd0, 3'd0);
    mem[191] = nop(3'd6, 1'b0, 3'd2, 3'd0, 3'd0);
    mem[192] = nop(3'd0, 1'b0, 3'd2, 3'd0, 3'd0);
    run(8'd190, 32'd1, 1'b0);
    chk_trace("R10", 1, 0, 0, 0, 0);
    chk("R10 error on reserved opcode", 32'(error), 32'd1);
    repeat (3) @(negedge clk);
    chk("R11 error held", 32'(error), 32'd1);
  endtask

  initial begin
    tr_n = 0; fa_n = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_straight();
    t_clear();
    t_branch_slot();
    t_annul();
    t_not_taken();
    t_backward();
    t_exit_in_slot();
    t_branch_in_slot();
    t_branch_in_exit_slot();
    t_reserved();
    t_straight();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule